// File: doc/BRIEF.md
# Four-Accumulator Pipelined Multiply-Accumulate Unit

This block is a signed multiply-accumulate datapath. Each cycle it can accept one operation that multiplies two register operands and adds the product to one of four accumulators, or subtracts it from that accumulator. An operand is either a full 32-bit word or one 16-bit half of a word, and the half is chosen separately for each operand. The multiply runs through a pipeline, but a new operation may enter on every clock with no stall. This holds even when consecutive operations target the same accumulator, because the add happens in the final stage against the live accumulator value.

Two per-operation mode bits shape the product. In integer mode the signed product is sign-extended or truncated to the accumulator width. In fractional mode the product is doubled to align the binary point, and then its upper 40 bits are kept. The bits below are either dropped or used for round-to-nearest-even. A combinational read port returns any accumulator unchanged. A sticky flag records any signed overflow of the 48-bit accumulation.

Top module: `mac_quad_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four accumulators read zero and `ovf_sticky` is 0 until an operation completes.
- R2: An operation presented with `op_valid` high at a rising edge reaches its accumulator at the third rising edge after that one. A new operation may be presented on every cycle, and back-to-back operations to the same accumulator all take effect.
- R3: Only the accumulator whose index is given on `op_acc` (0 to 3) changes. The other three keep their values.
- R4: With `op_wide`=0, operand A is `src_a[31:16]` when `op_hi_a`=1 and `src_a[15:0]` when it is 0. Operand B is chosen the same way by `op_hi_b`, independently of A.
- R5: Integer mode (`op_frac`=0): the term is the signed product of the operands. A 16-bit operand is sign-extended first. The low 48 bits of the product form the term.
- R6: Fractional mode with 16-bit operands: the term is the signed 32-bit product doubled, placed at accumulator bits [39:8], and sign-extended above.
- R7: Fractional mode with 32-bit operands and `op_round`=0: the 64-bit signed product is doubled. Its bits [63:24] form the term, sign-extended to 48 bits.
- R8: Fractional mode with `op_round`=1: the kept 40 bits are incremented when the discarded 24 bits exceed 0x800000. When they equal 0x800000, the kept value is incremented only if it is odd.
- R9: `op_sub`=1 subtracts the term from the accumulator, and `op_sub`=0 adds it. Both wrap modulo 2^48.
- R10: `ovf_sticky` sets when a signed 48-bit add or subtract overflows. It then stays set until reset.
- R11: `rd_data` shows the accumulator chosen by `rd_sel` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_sub | input | 1 | 1 subtracts the term, 0 adds it |
| op_wide | input | 1 | 1 uses full 32-bit operands, 0 uses 16-bit halves |
| op_hi_a | input | 1 | Half select for operand A |
| op_hi_b | input | 1 | Half select for operand B |
| op_frac | input | 1 | 1 fractional, 0 integer |
| op_round | input | 1 | Round-to-nearest-even in fractional mode |
| op_acc | input | 2 | Destination accumulator index |
| src_a | input | 32 | Source register A |
| src_b | input | 32 | Source register B |
| rd_sel | input | 2 | Accumulator to read |
| rd_data | output | 48 | Raw contents of the selected accumulator |
| ovf_sticky | output | 1 | Sticky signed-overflow flag |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 48-bit accumulator with 8 guard bits, four accumulators and the rounding variant enabled. With a 24-bit discarded field, the rounding ties at exactly 0x800000 can be reached from a small operand times one, for both even and odd kept values and for a negative product. With a 48-bit width, signed overflow is reachable with two integer products of 2^46. Operations are issued back to back, so every one of them meets the pipeline while earlier operations are still in flight.

// File: rtl/mac_quad_pkg.sv
package mac_quad_pkg;

   // Per-operation controls that travel down the pipeline
   typedef struct packed {
      logic sub;
      logic frac;
      logic rnd;
   } mac_ctl_t;

endpackage

// File: rtl/mac_quad_opsel.sv
// Stage 1: operand shaping (half selection, alignment) and capture.
module mac_quad_opsel
   import mac_quad_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_wide,
   input  logic              in_hi_a,
   input  logic              in_hi_b,
   input  mac_ctl_t          in_ctl,
   input  logic [SEL_W-1:0]  in_idx,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output mac_ctl_t          out_ctl,
   output logic [SEL_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_a,
   output logic [DATA_W-1:0] out_b
);

   localparam int HALF_W = DATA_W / 2;

   function automatic logic [DATA_W-1:0] shape_op(input logic [DATA_W-1:0] w,
                                                  input logic wide,
                                                  input logic hi,
                                                  input logic frac);
      logic [HALF_W-1:0] h;
      h = hi ? w[DATA_W-1 -: HALF_W] : w[HALF_W-1:0];
      if (wide)
         return w;
      else if (frac)
         return {h, {HALF_W{1'b0}}};
      else
         return {{HALF_W{h[HALF_W-1]}}, h};
   endfunction

   logic [DATA_W-1:0] a_d, b_d;

   always_comb begin
      a_d = shape_op(in_a, in_wide, in_hi_a, in_ctl.frac);
      b_d = shape_op(in_b, in_wide, in_hi_b, in_ctl.frac);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ctl   <= '0;
         out_idx   <= '0;
         out_a     <= '0;
         out_b     <= '0;
      end else begin
         out_valid <= in_valid;
         out_ctl   <= in_ctl;
         out_idx   <= in_idx;
         out_a     <= a_d;
         out_b     <= b_d;
      end
   end

endmodule

// File: rtl/mac_quad_mult.sv
// Stage 2: signed multiply, doubled for fractional alignment.
module mac_quad_mult
   import mac_quad_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2,
   localparam int PROD_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  mac_ctl_t          in_ctl,
   input  logic [SEL_W-1:0]  in_idx,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output mac_ctl_t          out_ctl,
   output logic [SEL_W-1:0]  out_idx,
   output logic [PROD_W-1:0] out_prod
);

   logic signed [PROD_W-1:0] ext_a, ext_b, raw_prod;
   logic        [PROD_W-1:0] aligned;

   always_comb begin
      ext_a    = {{DATA_W{in_a[DATA_W-1]}}, in_a};
      ext_b    = {{DATA_W{in_b[DATA_W-1]}}, in_b};
      raw_prod = ext_a * ext_b;
      aligned  = in_ctl.frac ? (raw_prod <<< 1) : raw_prod;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ctl   <= '0;
         out_idx   <= '0;
         out_prod  <= '0;
      end else begin
         out_valid <= in_valid;
         out_ctl   <= in_ctl;
         out_idx   <= in_idx;
         out_prod  <= aligned;
      end
   end

endmodule

// File: rtl/mac_quad_scale.sv
// Stage 3: reduce the product to an accumulator-width term.
module mac_quad_scale
   import mac_quad_pkg::*;
#(
   parameter int  DATA_W        = 32,
   parameter int  ACC_W         = 48,
   parameter int  GUARD_W       = 8,
   parameter int  SEL_W         = 2,
   parameter bit  ROUND_SUPPORT = 1'b1,
   localparam int PROD_W        = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  mac_ctl_t          in_ctl,
   input  logic [SEL_W-1:0]  in_idx,
   input  logic [PROD_W-1:0] in_prod,
   output logic              out_valid,
   output logic              out_sub,
   output logic [SEL_W-1:0]  out_idx,
   output logic [ACC_W-1:0]  out_term
);

   localparam int KEEP_W = ACC_W - GUARD_W;
   localparam int DROP_W = PROD_W - KEEP_W;
   localparam logic [DROP_W-1:0] TIE_VAL = {1'b1, {(DROP_W-1){1'b0}}};

   logic [KEEP_W-1:0] kept, kept_r;
   logic [DROP_W-1:0] dropped;
   logic [ACC_W-1:0]  term_d;

   assign kept    = in_prod[PROD_W-1 -: KEEP_W];
   assign dropped = in_prod[DROP_W-1:0];

   generate
      if (ROUND_SUPPORT) begin : g_round
         logic bump;
         always_comb begin
            bump = in_ctl.rnd &&
                   ((dropped > TIE_VAL) || ((dropped == TIE_VAL) && kept[0]));
            kept_r = kept + KEEP_W'(bump);
         end
      end else begin : g_trunc
         assign kept_r = kept;
      end
   endgenerate

   always_comb begin
      if (in_ctl.frac)
         term_d = {{GUARD_W{kept_r[KEEP_W-1]}}, kept_r};
      else
         term_d = in_prod[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sub   <= 1'b0;
         out_idx   <= '0;
         out_term  <= '0;
      end else begin
         out_valid <= in_valid;
         out_sub   <= in_ctl.sub;
         out_idx   <= in_idx;
         out_term  <= term_d;
      end
   end

endmodule

// File: rtl/mac_quad_accbank.sv
// Stage 4: accumulator bank with add/subtract and sticky overflow.
module mac_quad_accbank #(
   parameter int ACC_W   = 48,
   parameter int NUM_ACC = 4,
   parameter int SEL_W   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          in_sub,
   input  logic [SEL_W-1:0]              in_idx,
   input  logic [ACC_W-1:0]              in_term,
   output logic [NUM_ACC-1:0][ACC_W-1:0] acc_flat,
   output logic                          ovf
);

   logic [ACC_W-1:0] cur, nxt;
   logic             ovf_now;

   always_comb begin
      cur = acc_flat[in_idx];
      nxt = in_sub ? (cur - in_term) : (cur + in_term);
      if (in_sub)
         ovf_now = (cur[ACC_W-1] != in_term[ACC_W-1]) && (nxt[ACC_W-1] != cur[ACC_W-1]);
      else
         ovf_now = (cur[ACC_W-1] == in_term[ACC_W-1]) && (nxt[ACC_W-1] != cur[ACC_W-1]);
   end

   generate
      for (genvar j = 0; j < NUM_ACC; j++) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n)
               acc_flat[j] <= '0;
            else if (in_valid && (in_idx == SEL_W'(j)))
               acc_flat[j] <= nxt;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (in_valid && ovf_now)
         ovf <= 1'b1;
   end

endmodule

// File: rtl/mac_quad_unit.sv
// Top: four-stage MAC with a bank of accumulators.
module mac_quad_unit
   import mac_quad_pkg::*;
#(
   parameter int  DATA_W        = 32,
   parameter int  ACC_W         = 48,
   parameter int  GUARD_W       = 8,
   parameter int  NUM_ACC       = 4,
   parameter bit  ROUND_SUPPORT = 1'b1,
   localparam int SEL_W         = $clog2(NUM_ACC),
   localparam int PROD_W        = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_sub,
   input  logic              op_wide,
   input  logic              op_hi_a,
   input  logic              op_hi_b,
   input  logic              op_frac,
   input  logic              op_round,
   input  logic [SEL_W-1:0]  op_acc,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [ACC_W-1:0]  rd_data,
   output logic              ovf_sticky
);

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("DATA_W must be even");
      end
      if (NUM_ACC < 2) begin : g_bad_num
         $error("NUM_ACC must be at least 2");
      end
      if (ACC_W > PROD_W || ACC_W - GUARD_W <= DATA_W) begin : g_bad_acc
         $error("ACC_W must not exceed 2*DATA_W and must keep more than DATA_W bits");
      end
   endgenerate

   mac_ctl_t          in_ctl, s1_ctl, s2_ctl;
   logic              s1_valid, s2_valid, s3_valid, s3_sub;
   logic [SEL_W-1:0]  s1_idx, s2_idx, s3_idx;
   logic [DATA_W-1:0] s1_a, s1_b;
   logic [PROD_W-1:0] s2_prod;
   logic [ACC_W-1:0]  s3_term;
   logic [NUM_ACC-1:0][ACC_W-1:0] acc_flat;

   assign in_ctl = '{sub: op_sub, frac: op_frac, rnd: op_round};

   mac_quad_opsel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) opsel_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(op_valid), .in_wide(op_wide), .in_hi_a(op_hi_a), .in_hi_b(op_hi_b),
      .in_ctl(in_ctl), .in_idx(op_acc), .in_a(src_a), .in_b(src_b),
      .out_valid(s1_valid), .out_ctl(s1_ctl), .out_idx(s1_idx),
      .out_a(s1_a), .out_b(s1_b)
   );

   mac_quad_mult #(.DATA_W(DATA_W), .SEL_W(SEL_W)) mult_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s1_valid), .in_ctl(s1_ctl), .in_idx(s1_idx),
      .in_a(s1_a), .in_b(s1_b),
      .out_valid(s2_valid), .out_ctl(s2_ctl), .out_idx(s2_idx), .out_prod(s2_prod)
   );

   mac_quad_scale #(.DATA_W(DATA_W), .ACC_W(ACC_W), .GUARD_W(GUARD_W),
                    .SEL_W(SEL_W), .ROUND_SUPPORT(ROUND_SUPPORT)) scale_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s2_valid), .in_ctl(s2_ctl), .in_idx(s2_idx), .in_prod(s2_prod),
      .out_valid(s3_valid), .out_sub(s3_sub), .out_idx(s3_idx), .out_term(s3_term)
   );

   mac_quad_accbank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s3_valid), .in_sub(s3_sub), .in_idx(s3_idx), .in_term(s3_term),
      .acc_flat(acc_flat), .ovf(ovf_sticky)
   );

   assign rd_data = acc_flat[rd_sel];

endmodule

// File: rtl/mac_quad_unit_chk.sv
module mac_quad_unit_chk #(
   parameter int ACC_W   = 48,
   parameter int NUM_ACC = 4,
   parameter int SEL_W   = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          op_valid,
   input logic                          s3_valid,
   input logic [SEL_W-1:0]              s3_idx,
   input logic [NUM_ACC-1:0][ACC_W-1:0] acc_flat,
   input logic                          ovf
);

   // R10
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R10
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(s3_valid));

   // R2
   issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (s3_valid == $past(op_valid, 3)));

   // R3
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s3_valid |=> $stable(acc_flat));

   generate
      for (genvar j = 0; j < NUM_ACC; j++) begin : g_other
         // R3
         other_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s3_valid && (s3_idx != SEL_W'(j))) |=> $stable(acc_flat[j]));
      end
   endgenerate

endmodule

bind mac_quad_unit mac_quad_unit_chk #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
   .s3_valid(s3_valid), .s3_idx(s3_idx), .acc_flat(acc_flat), .ovf(ovf_sticky)
);

// File: tb/mac_quad_unit_tb_top.sv
module mac_quad_unit_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 0, op_sub = 0, op_wide = 0, op_hi_a = 0, op_hi_b = 0;
   logic        op_frac = 0, op_round = 0;
   logic [1:0]  op_acc = '0, rd_sel = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [47:0] rd_data;
   logic        ovf_sticky;

   int checks = 0, errors = 0, cnt = 0;
   bit done = 0;

   typedef struct {
      int          due;
      int          idx;
      logic [47:0] val;
      bit          ovf;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   logic [47:0] model_acc [4];
   bit          model_ovf;

   mac_quad_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub), .op_wide(op_wide),
      .op_hi_a(op_hi_a), .op_hi_b(op_hi_b), .op_frac(op_frac), .op_round(op_round),
      .op_acc(op_acc), .src_a(src_a), .src_b(src_b), .rd_sel(rd_sel),
      .rd_data(rd_data), .ovf_sticky(ovf_sticky)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cnt <= cnt + 1;

   // Reference term from the requirement text (R4..R8)
   function automatic logic [47:0] exp_term(input bit wide, input bit hia, input bit hib,
                                            input bit frac, input bit rnd,
                                            input logic [31:0] a, input logic [31:0] b);
      logic [15:0] ha, hb;
      logic [31:0] oa, ob;
      longint      p;
      logic [63:0] full;
      logic [39:0] t;
      logic [23:0] lo;
      ha = hia ? a[31:16] : a[15:0];
      hb = hib ? b[31:16] : b[15:0];
      if (wide) begin oa = a; ob = b; end
      else if (frac) begin oa = {ha, 16'h0}; ob = {hb, 16'h0}; end
      else begin oa = {{16{ha[15]}}, ha}; ob = {{16{hb[15]}}, hb}; end
      p = longint'($signed(oa)) * longint'($signed(ob));
      if (!frac) return p[47:0];
      full = 64'(p) << 1;
      t  = full[63:24];
      lo = full[23:0];
      if (rnd && ((lo > 24'h800000) || (lo == 24'h800000 && t[0]))) t = t + 40'd1;
      return {{8{t[39]}}, t};
   endfunction

   task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic issue(input string tag, input bit sub, input bit wide, input bit hia,
                        input bit hib, input bit frac, input bit rnd, input int idx,
                        input logic [31:0] a, input logic [31:0] b);
      logic [47:0] term, old, nxt;
      item_t it;
      @(negedge clk);
      op_valid = 1; op_sub = sub; op_wide = wide; op_hi_a = hia; op_hi_b = hib;
      op_frac = frac; op_round = rnd; op_acc = 2'(idx); src_a = a; src_b = b;
      term = exp_term(wide, hia, hib, frac, rnd, a, b);
      old  = model_acc[idx];
      nxt  = sub ? old - term : old + term;
      if (sub ? (old[47] != term[47] && nxt[47] != old[47])
              : (old[47] == term[47] && nxt[47] != old[47])) model_ovf = 1;
      model_acc[idx] = nxt;
      it.due = cnt + 4; it.idx = idx; it.val = nxt; it.ovf = model_ovf; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      op_valid = 0;
   endtask

   // Monitor: compares results in the cycle they are due
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0 && sb_q[0].due == cnt) begin
            it = sb_q.pop_front();
            rd_sel = 2'(it.idx);
            #1;
            check(it.tag, rd_data, it.val);
            check({it.tag, " R10 flag"}, {47'd0, ovf_sticky}, {47'd0, it.ovf});
         end
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model_acc[i] = '0;
      model_ovf = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #3;
      // R1: reset state
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i);
         #1;
         check("R1 reset acc", rd_data, 48'd0);
      end
      check("R1 reset flag", {47'd0, ovf_sticky}, 48'd0);
      rst_n = 1;

      // R5 integer, low halves: -2 * 3
      issue("R5 int narrow",  0, 0, 0, 0, 0, 0, 0, 32'h1234FFFE, 32'hABCD0003);
      // R4 independent half selection
      issue("R4 hi a lo b",   0, 0, 1, 0, 0, 0, 0, 32'h1234FFFE, 32'hABCD0003);
      issue("R4 lo a hi b",   0, 0, 0, 1, 0, 0, 0, 32'h1234FFFE, 32'hABCD0003);
      issue("R5 int wide",    0, 1, 0, 0, 0, 0, 1, 32'h00012345, 32'hFFFF0010);
      // R6 fractional halves
      issue("R6 frac narrow", 0, 0, 1, 1, 1, 0, 2, 32'h4000_0000, 32'h4000_0000);
      issue("R6 frac neg",    0, 0, 0, 0, 1, 0, 2, 32'h0000_C000, 32'h0000_6000);
      // R7 truncation of wide fractional product
      issue("R7 frac trunc",  0, 1, 0, 0, 1, 0, 1, 32'h12345678, 32'h0ABCDEF1);
      // R8 rounding: tie odd, tie even, above half, below half, negative tie
      issue("R8 tie odd",     0, 1, 0, 0, 1, 1, 2, 32'h00C00000, 32'h00000001);
      issue("R8 tie even",    0, 1, 0, 0, 1, 1, 2, 32'h00400000, 32'h00000001);
      issue("R8 above half",  0, 1, 0, 0, 1, 1, 2, 32'h00600000, 32'h00000001);
      issue("R8 below half",  0, 1, 0, 0, 1, 1, 2, 32'h00200000, 32'h00000001);
      issue("R8 neg tie",     0, 1, 0, 0, 1, 1, 2, 32'hFFC00000, 32'h00000001);
      issue("R8 round wide",  0, 1, 0, 0, 1, 1, 1, 32'h12345678, 32'h0ABCDEF1);
      // R9 subtract
      issue("R9 sub",         1, 0, 0, 0, 0, 0, 1, 32'h00007FFF, 32'h00000100);
      issue("R9 sub frac",    1, 1, 0, 0, 1, 0, 0, 32'h40000000, 32'h20000000);
      // R2 back to back on the same accumulator
      issue("R2 b2b 1",       0, 1, 0, 0, 0, 0, 0, 32'h00001000, 32'h00000111);
      issue("R2 b2b 2",       0, 1, 0, 0, 0, 0, 0, 32'h00002000, 32'h00000222);
      issue("R2 b2b 3",       1, 0, 1, 1, 0, 0, 0, 32'h7FFF0000, 32'h7FFF0000);
      // R10 overflow: two 2^46 products exceed the signed 48-bit range
      issue("R10 near max",   0, 1, 0, 0, 0, 0, 3, 32'h00800000, 32'h00800000);
      issue("R10 overflow",   0, 1, 0, 0, 0, 0, 3, 32'h00800000, 32'h00800000);
      issue("R10 sticky",     0, 0, 0, 0, 0, 0, 1, 32'h00000001, 32'h00000001);
      idle();
      repeat (8) @(negedge clk);

      // R3 and R11: every accumulator holds exactly its own history
      #3;
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i);
         #1;
         check("R3 R11 final sweep", rd_data, model_acc[i]);
      end
      if (sb_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R2 pending=%0d expected=0", sb_q.size());
      end
      done = 1;
      summary();
      $finish;
   end

endmodule